// File: doc/BRIEF.md
# Four-Queue Read Port with Null Queue Select

This block is the read side of a FIFO store split into four queues. A 6-bit read address picks the queue to draw from on each clock. A two-stage pipeline (a prefetch register followed by the output register) keeps pulling the next words of the addressed queue, so a reader holding read enable gets one word per clock. When the address moves from one queue to another, the words already in the pipeline still reach the output and no clock is lost.

Any address with bit 2 set picks the null queue. The null queue is always empty. Choosing it lets the pipeline drain the previous queue's words to the output without taking any new word from any queue. Once the pipeline is empty, the output register keeps the last word it delivered, and the active-low output-valid flag reads high. A small write port loads the four internal queues so the block can be used and tested on its own.

Top module: `mq_read_port`

## Requirements
- R1: During and right after reset, `rd_ovalid_n` is 1 and `rd_data` is 0.
- R2: With address bit 2 clear, address bits 1:0 pick queue 0 to 3, and address bits 5:3 have no effect.
- R3: With address bit 2 set (the null queue), no word leaves any queue. The output stays invalid once the pipeline is empty.
- R4: The words of one queue reach `rd_data` in the order in which they were written.
- R5: While `rd_en` is held and the addressed queues have data, one word is delivered on every clock, including the clocks at queue switches.
- R6: With `rd_en` low and an empty pipeline, addressing a non-empty queue presents its head word with `rd_ovalid_n` low after the second rising edge. After the first rising edge `rd_ovalid_n` is still 1.
- R7: Switching to the null queue still delivers the words already in the pipeline. After that, `rd_data` holds the last delivered word and `rd_ovalid_n` is 1.
- R8: `rd_en` asserted while `rd_ovalid_n` is 1 and the pipeline is empty changes neither output.
- R9: When the addressed queue is empty, consuming the last word sets `rd_ovalid_n` to 1 and leaves that word on `rd_data`.
- R10: A write to a queue that already holds DEPTH words is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read and write clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for loading a queue |
| wr_queue | input | 2 | Queue index the write goes to |
| wr_data | input | DW | Word to write |
| rd_addr | input | 6 | Read address; bit 2 set means null queue, else bits 1:0 pick the queue |
| rd_en | input | 1 | Consume the word in the output register at this edge |
| rd_data | output | DW | Output register |
| rd_ovalid_n | output | 1 | Low when rd_data holds a word not yet consumed |

## Verification
The bench runs a continuous read stream with the address walking through all four queues, using varied upper address bits. This shows whether words arrive in order, one per clock, across each switch, and whether the tail drains into the null queue and holds there. A sweep over all 64 read addresses loads one word per non-null address and confirms that exactly that word appears. The same sweep checks that every address with bit 2 set leaves the output untouched. Writes beyond the queue depth, reads against an empty pipeline and selection of empty queues separate discarded writes from lost or duplicated words.

// File: rtl/mq_read_port.sv
module mq_read_port #(
  parameter int DW       = 8,
  parameter int DEPTH    = 4,
  parameter int ADDR_W   = 6,
  parameter int NULL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_queue,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  output logic              rd_ovalid_n
);
  localparam int NQ = 4;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

  logic [DW-1:0] mem [NQ][DEPTH];
  logic [PW-1:0] wp [NQ];
  logic [PW-1:0] rp [NQ];
  logic [PW:0]   cnt [NQ];

  logic          pf_v;
  logic [DW-1:0] pf_d;
  logic [DW-1:0] out_d;
  logic          ov_n;

  wire       is_null  = rd_addr[NULL_BIT];
  wire [1:0] rq       = rd_addr[1:0];
  wire       out_load = pf_v && (ov_n || rd_en);
  wire       pf_free  = !pf_v || out_load;
  wire       pop      = pf_free && !is_null && (cnt[rq] != '0);
  wire       push     = wr_en && (cnt[wr_queue] != FULL);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push) mem[wr_queue][wp[wr_queue]] <= wr_data;

  always_ff @(posedge clk) begin
    for (int q = 0; q < NQ; q++) begin
      if (!rst_n) begin
        wp[q]  <= '0;
        rp[q]  <= '0;
        cnt[q] <= '0;
      end else begin
        if (push && wr_queue == 2'(q)) wp[q] <= nxt(wp[q]);
        if (pop && rq == 2'(q))        rp[q] <= nxt(rp[q]);
        if ((push && wr_queue == 2'(q)) && !(pop && rq == 2'(q)))
          cnt[q] <= cnt[q] + 1'b1;
        else if (!(push && wr_queue == 2'(q)) && (pop && rq == 2'(q)))
          cnt[q] <= cnt[q] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_v  <= 1'b0;
      pf_d  <= '0;
      out_d <= '0;
      ov_n  <= 1'b1;
    end else begin
      if (pop) begin
        pf_v <= 1'b1;
        pf_d <= mem[rq][rp[rq]];
      end else if (out_load) begin
        pf_v <= 1'b0;
      end
      if (out_load) begin
        out_d <= pf_d;
        ov_n  <= 1'b0;
      end else if (rd_en) begin
        ov_n  <= 1'b1;
      end
    end
  end

  assign rd_data     = out_d;
  assign rd_ovalid_n = ov_n;

  for (genvar g = 0; g < NQ; g++) begin : g_chk
    p_null_no_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_null && !(wr_en && wr_queue == 2'(g))) |=> cnt[g] == $past(cnt[g]));
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= FULL);
  end

  p_stream_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ov_n && rd_en && pf_v) |=> !ov_n);
  p_idle_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_n && !pf_v) |=> ov_n && $stable(rd_data));
  p_consume_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ov_n && rd_en && !pf_v) |=> ov_n && $stable(rd_data));
  p_pipe_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_n && pf_v) |=> !ov_n);
endmodule

// File: tb/test_mq_read_port.sv
module test_mq_read_port;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_queue;
  logic [DW-1:0] wr_data;
  logic [5:0]    rd_addr;
  logic          rd_en;
  logic [DW-1:0] rd_data;
  logic          rd_ovalid_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mq_read_port #(.DW(DW), .DEPTH(4)) i_mq_read_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_queue(wr_queue),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_en(rd_en),
    .rd_data(rd_data), .rd_ovalid_n(rd_ovalid_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  function automatic logic [5:0] sched(input int j);
    if (j < 2)  return {3'b011, 1'b0, 2'd0};
    if (j < 14) return {3'(j), 1'b0, 2'((j - 2) / 4 + 1)};
    return {3'(j), 1'b1, 2'(j)};
  endfunction

  initial begin
    logic [DW-1:0] got [20];
    int ngot;
    int bubbles;
    logic [DW-1:0] last;

    rst_n = 1'b0; wr_en = 1'b0; wr_queue = '0; wr_data = '0;
    rd_addr = 6'b000100; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ovalid_n", 32'(rd_ovalid_n), 1);
    chk("R1 data", 32'(rd_data), 0);
    rst_n = 1'b1;

    // load five words per queue; fifth must be dropped (R10), null address held (R3)
    for (int q = 0; q < 4; q++)
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_queue = 2'(q); wr_data = DW'(q * 16 + i);
        rd_addr = {3'(q + i), 1'b1, 2'(i)};
      end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 null pulls nothing", 32'(rd_ovalid_n), 1);

    // R6 fall-through latency
    rd_addr = 6'b101000;
    @(negedge clk);
    chk("R6 after one edge", 32'(rd_ovalid_n), 1);
    @(negedge clk);
    chk("R6 after two edges", 32'(rd_ovalid_n), 0);
    chk("R6 head word", 32'(rd_data), 32'h00);

    // R5/R4/R7 continuous stream across all queues, then null
    ngot = 0; bubbles = 0;
    for (int j = 0; j < 20; j++) begin
      if (!rd_ovalid_n) begin
        if (ngot < 20) got[ngot] = rd_data;
        ngot++;
      end else if (j < 16) bubbles++;
      rd_en = 1'b1;
      rd_addr = sched(j);
      @(negedge clk);
    end
    rd_en = 1'b0;
    chk("R5 words streamed", 32'(ngot), 16);
    chk("R5 idle clocks", 32'(bubbles), 0);
    for (int k = 0; k < 16; k++)
      chk($sformatf("R4 word %0d", k), 32'(got[k]), 32'((k / 4) * 16 + k % 4));
    chk("R7 ovalid_n after null drain", 32'(rd_ovalid_n), 1);
    chk("R7 last word held", 32'(rd_data), 32'h33);

    // R8 reads with nothing to read
    rd_addr = 6'b110101; rd_en = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R8 ovalid_n", 32'(rd_ovalid_n), 1);
      chk("R8 data", 32'(rd_data), 32'h33);
    end

    // R9 empty queue selected
    rd_addr = 6'b000001;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R9 ovalid_n", 32'(rd_ovalid_n), 1);
      chk("R9 data", 32'(rd_data), 32'h33);
    end
    rd_en = 1'b0;

    // R10 no fifth word left in any queue
    for (int q = 0; q < 4; q++) begin
      rd_addr = 6'(q);
      repeat (3) @(negedge clk);
      chk($sformatf("R10 queue %0d empty", q), 32'(rd_ovalid_n), 1);
    end

    // R2/R3 sweep of every read address
    last = 8'h33;
    for (int a = 0; a < 64; a++) begin
      if (a[2]) begin
        rd_addr = 6'(a);
        repeat (2) @(negedge clk);
        chk($sformatf("R3 addr %0d ovalid_n", a), 32'(rd_ovalid_n), 1);
        chk($sformatf("R3 addr %0d data", a), 32'(rd_data), 32'(last));
      end else begin
        wr_en = 1'b1; wr_queue = 2'(a); wr_data = DW'(a); rd_addr = 6'b000100;
        @(negedge clk);
        wr_en = 1'b0; rd_addr = 6'(a);
        repeat (2) @(negedge clk);
        chk($sformatf("R2 addr %0d ovalid_n", a), 32'(rd_ovalid_n), 0);
        chk($sformatf("R2 addr %0d data", a), 32'(rd_data), 32'(a));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk($sformatf("R9 addr %0d consumed", a), 32'(rd_ovalid_n), 1);
        chk($sformatf("R9 addr %0d held", a), 32'(rd_data), 32'(a));
        last = DW'(a);
      end
    end

    summary();
    $finish;
  end
endmodule